// File: doc/BRIEF.md
# Dual-Identity Serial Memory Target

This block is the target side of a two-wire serial bus (I2C) placed in front of a byte-wide memory of 128K locations and a small control-register bank. It samples SCL and SDA with the system clock and detects START and STOP. It then decodes the byte that follows START. One slave byte can address either of two 4-bit identities. The memory identity streams bytes to and from a synchronous memory port. The control identity streams bytes to and from a register port. Both identities are gated by two device-select pins, so several targets can share one bus.

The memory needs a 17-bit address, but only two address bytes follow the slave byte. The top address bit travels in the slave byte itself. Each transferred data byte advances an internal pointer. A read starts at whatever the pointer holds. To aim a read, the master performs an address-only write and then issues a repeated START. SDA is open-drain: the block only ever asks for the line to be pulled low.

Top module: `dual_id_i2c_target`

## Requirements
- R1: After reset, sda_oe, mem_we, mem_re, reg_we and reg_re are all 0.
- R2: The first byte after a START is the slave byte, shifted MSB first. Bits 7:4 equal to 1010 select the memory identity and 0011 select the control identity. Bits 3:2 must equal dev_sel. Bit 0 set to 1 means read and 0 means write. A matching slave byte is acknowledged by holding SDA low during the ninth clock.
- R3: A slave byte with any other identity or device-select value is not acknowledged. Until the next START the block then drives no SDA low and produces no memory or register write.
- R4: A memory write uses slave bit 1 as address bit 16. The next two bytes give address bits 15:8 and then 7:0. Each later byte is written through one mem_we cycle at mem_addr with mem_wdata. Every byte is acknowledged.
- R5: After every data byte the memory pointer increments by one and wraps from 0x1FFFF to 0x00000.
- R6: A memory read takes address bit 16 from slave bit 1 and bits 15:0 from the current pointer. Each byte is fetched with mem_re and taken from mem_rdata one cycle later. It is sent MSB first and changes only while SCL is low. An address-only write followed by a repeated START sets the read start address.
- R7: On the control identity, slave bit 1 is ignored. The first written byte sets the register index, whose low CREG_AW bits are used. Later bytes are written through reg_we. Reads fetch through reg_re. The index wraps modulo 2^CREG_AW.
- R8: When the master does not acknowledge a read byte, the block releases SDA and stays off the bus until the next START. The pointer then holds the address after the last byte sent.
- R9: A START received in any state, including in the middle of a byte, abandons the transfer and begins a new slave byte.
- R10: mem_re and reg_re are single-cycle pulses. After each mem_we cycle, mem_addr holds the written address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_sel | input | 2 | Device-select value compared with slave bits 3:2 |
| mem_addr | output | MEM_AW (17) | Memory pointer / access address |
| mem_wdata | output | DW (8) | Byte to write |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_re | output | 1 | One-cycle memory read strobe |
| mem_rdata | input | DW (8) | Memory data, valid the cycle after mem_re |
| reg_addr | output | CREG_AW (4) | Control-register index |
| reg_wdata | output | DW (8) | Register byte to write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | DW (8) | Register data, valid the cycle after reg_re |

## Verification
The bench builds the block with its defaults: a 17-bit memory address, a 4-bit register index and two synchronizer stages. With a 17-bit pointer, the wrap from 0x1FFFF to 0x00000 can be reached with one two-byte write at address 0xFFFF with bit 16 set. The 4-bit register index lets a three-byte burst starting at index 14 cross its own wrap. Each bus bit spans forty system clocks, so the two-stage synchronizer delay sits well inside each SCL phase.

// File: rtl/dit_pkg.sv
package dit_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLAVE,
      ST_ACK,
      ST_WRX,
      ST_RTX,
      ST_MACK,
      ST_SKIP
   } dit_state_e;

   typedef enum logic [1:0] {
      PH_IDX_HI,
      PH_IDX_LO,
      PH_DATA
   } dit_phase_e;

   typedef enum logic {
      ID_MEM,
      ID_CTL
   } dit_ident_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] ff;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= '1;
         else        ff <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= '1;
         else        ff <= {ff[STAGES-2:0], d};
      end
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic scl_d;
   logic sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl;
         sda_d <= sda;
      end
   end

   assign scl_rise = scl & ~scl_d;
   assign scl_fall = ~scl & scl_d;
   assign start_ev = scl & scl_d & sda_d & ~sda;
   assign stop_ev  = scl & scl_d & ~sda_d & sda;

endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic [W-1:0] set_val,
   input  logic         inc,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("i2c_addr_ptr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (set_en) q <= set_val;
      else if (inc)    q <= q + 1'b1;
   end

   // R5
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !set_en && (q == {W{1'b1}})) |=> (q == '0));

endmodule

// File: rtl/dual_id_i2c_target.sv
module dual_id_i2c_target
   import dit_pkg::*;
#(
   parameter int         MEM_AW      = 17,
   parameter int         DW          = 8,
   parameter int         CREG_AW     = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] MEM_ID      = 4'b1010,
   parameter logic [3:0] CTL_ID      = 4'b0011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [1:0]         dev_sel,
   output logic [MEM_AW-1:0]  mem_addr,
   output logic [DW-1:0]      mem_wdata,
   output logic               mem_we,
   output logic               mem_re,
   input  logic [DW-1:0]      mem_rdata,
   output logic [CREG_AW-1:0] reg_addr,
   output logic [DW-1:0]      reg_wdata,
   output logic               reg_we,
   output logic               reg_re,
   input  logic [DW-1:0]      reg_rdata
);

   localparam int BIT_CW = $clog2(DW + 1);
   localparam logic [BIT_CW-1:0] FULL_CNT = BIT_CW'(DW);

   if (DW != 8) begin : g_bad_dw
      $error("dual_id_i2c_target: DW must be 8");
   end
   if (MEM_AW != 2 * DW + 1) begin : g_bad_aw
      $error("dual_id_i2c_target: MEM_AW must equal two bytes plus one");
   end
   if (CREG_AW < 1 || CREG_AW > DW) begin : g_bad_creg
      $error("dual_id_i2c_target: CREG_AW out of range");
   end
   if (MEM_ID == CTL_ID) begin : g_bad_id
      $error("dual_id_i2c_target: identities must differ");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2c_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   dit_state_e        state;
   dit_phase_e        phase;
   dit_ident_e        ident;
   logic              rw;
   logic [BIT_CW-1:0] bitcnt;
   logic [DW-1:0]     rx_sh;
   logic [DW-1:0]     tx_sh;
   logic              mack;
   logic              fetch_pend;
   logic              re_d;

   logic slave_done, wr_done, rd_done;
   logic hit_mem, hit_ctl, hit_any;

   assign slave_done = (state == ST_SLAVE) && scl_fall && (bitcnt == FULL_CNT);
   assign wr_done    = (state == ST_WRX)   && scl_fall && (bitcnt == FULL_CNT);
   assign rd_done    = (state == ST_RTX)   && scl_fall && (bitcnt == FULL_CNT);

   assign hit_mem = (rx_sh[7:4] == MEM_ID) && (rx_sh[3:2] == dev_sel);
   assign hit_ctl = (rx_sh[7:4] == CTL_ID) && (rx_sh[3:2] == dev_sel);
   assign hit_any = hit_mem | hit_ctl;

   logic              mptr_set, mptr_inc;
   logic [MEM_AW-1:0] mptr_val, mptr_q;
   logic              cptr_set, cptr_inc;
   logic [CREG_AW-1:0] cptr_val, cptr_q;

   always_comb begin
      mptr_set = 1'b0;
      mptr_val = mptr_q;
      if (!start_ev && !stop_ev) begin
         if (slave_done && hit_mem) begin
            mptr_set = 1'b1;
            mptr_val = {rx_sh[1], mptr_q[MEM_AW-2:0]};
         end else if (wr_done && ident == ID_MEM && phase == PH_IDX_HI) begin
            mptr_set = 1'b1;
            mptr_val = {mptr_q[MEM_AW-1], rx_sh, mptr_q[DW-1:0]};
         end else if (wr_done && ident == ID_MEM && phase == PH_IDX_LO) begin
            mptr_set = 1'b1;
            mptr_val = {mptr_q[MEM_AW-1:DW], rx_sh};
         end
      end
   end

   assign mptr_inc = mem_we | (rd_done && ident == ID_MEM && !start_ev && !stop_ev);

   assign cptr_set = wr_done && ident == ID_CTL && phase == PH_IDX_HI
                     && !start_ev && !stop_ev;
   assign cptr_val = rx_sh[CREG_AW-1:0];
   assign cptr_inc = reg_we | (rd_done && ident == ID_CTL && !start_ev && !stop_ev);

   i2c_addr_ptr #(.W(MEM_AW)) u_mem_ptr (
      .clk(clk), .rst_n(rst_n), .set_en(mptr_set), .set_val(mptr_val),
      .inc(mptr_inc), .q(mptr_q));

   i2c_addr_ptr #(.W(CREG_AW)) u_reg_ptr (
      .clk(clk), .rst_n(rst_n), .set_en(cptr_set), .set_val(cptr_val),
      .inc(cptr_inc), .q(cptr_q));

   assign mem_addr = mptr_q;
   assign reg_addr = cptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         phase      <= PH_IDX_HI;
         ident      <= ID_MEM;
         rw         <= 1'b0;
         bitcnt     <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         mack       <= 1'b0;
         fetch_pend <= 1'b0;
         re_d       <= 1'b0;
         sda_oe     <= 1'b0;
         mem_we     <= 1'b0;
         mem_re     <= 1'b0;
         reg_we     <= 1'b0;
         reg_re     <= 1'b0;
         mem_wdata  <= '0;
         reg_wdata  <= '0;
      end else begin
         mem_we <= 1'b0;
         reg_we <= 1'b0;
         mem_re <= 1'b0;
         reg_re <= 1'b0;
         re_d   <= mem_re | reg_re;
         if (re_d) tx_sh <= (ident == ID_MEM) ? mem_rdata : reg_rdata;
         if (fetch_pend) begin
            fetch_pend <= 1'b0;
            if (ident == ID_MEM) mem_re <= 1'b1;
            else                 reg_re <= 1'b1;
         end

         if (start_ev) begin
            state      <= ST_SLAVE;
            bitcnt     <= '0;
            sda_oe     <= 1'b0;
            fetch_pend <= 1'b0;
         end else if (stop_ev) begin
            state      <= ST_IDLE;
            sda_oe     <= 1'b0;
            fetch_pend <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE, ST_SKIP: ;
               ST_SLAVE: begin
                  if (scl_rise && bitcnt != FULL_CNT) begin
                     rx_sh  <= {rx_sh[DW-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end
                  if (slave_done) begin
                     if (hit_any) begin
                        ident  <= hit_mem ? ID_MEM : ID_CTL;
                        rw     <= rx_sh[0];
                        phase  <= PH_IDX_HI;
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                        if (rx_sh[0]) begin
                           if (hit_mem) mem_re <= 1'b1;
                           else         reg_re <= 1'b1;
                        end
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        sda_oe <= ~tx_sh[DW-1];
                        tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                        state  <= ST_RTX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WRX;
                     end
                  end
               end
               ST_WRX: begin
                  if (scl_rise && bitcnt != FULL_CNT) begin
                     rx_sh  <= {rx_sh[DW-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end
                  if (wr_done) begin
                     sda_oe <= 1'b1;
                     state  <= ST_ACK;
                     unique case (phase)
                        PH_IDX_HI: phase <= (ident == ID_MEM) ? PH_IDX_LO : PH_DATA;
                        PH_IDX_LO: phase <= PH_DATA;
                        default: begin
                           if (ident == ID_MEM) begin
                              mem_we    <= 1'b1;
                              mem_wdata <= rx_sh;
                           end else begin
                              reg_we    <= 1'b1;
                              reg_wdata <= rx_sh;
                           end
                        end
                     endcase
                  end
               end
               ST_RTX: begin
                  if (scl_rise && bitcnt != FULL_CNT) bitcnt <= bitcnt + 1'b1;
                  if (scl_fall) begin
                     if (bitcnt == FULL_CNT) begin
                        sda_oe     <= 1'b0;
                        state      <= ST_MACK;
                        fetch_pend <= 1'b1;
                     end else begin
                        sda_oe <= ~tx_sh[DW-1];
                        tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (mack) begin
                        sda_oe <= ~tx_sh[DW-1];
                        tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                        state  <= ST_RTX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_SKIP;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R2
   sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R3
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> (!sda_oe && !mem_we && !reg_we));

   // R8
   mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MACK) |-> !sda_oe);

   // R10
   mem_re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re);

   // R10
   reg_re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   // R10
   mem_we_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

endmodule

// File: tb/dual_id_i2c_target_tb_top.sv
module dual_id_i2c_target_tb_top;

   localparam int Q = 10;
   localparam logic [1:0] DS = 2'b10;
   localparam logic [3:0] IDM = 4'b1010;
   localparam logic [3:0] IDC = 4'b0011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [16:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata, reg_wdata, reg_rdata;
   logic        mem_we, mem_re, reg_we, reg_re;
   logic [3:0]  reg_addr;

   always #10 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   dual_id_i2c_target dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .dev_sel(DS),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .mem_rdata(mem_rdata),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_re(reg_re), .reg_rdata(reg_rdata));

   // storage seen by the device
   logic [7:0] dev_mem [int];
   logic [7:0] dev_reg [16];
   always @(posedge clk) begin
      if (mem_we) dev_mem[int'(mem_addr)] = mem_wdata;
      if (mem_re) mem_rdata <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 8'h00;
      if (reg_we) dev_reg[reg_addr] = reg_wdata;
      if (reg_re) reg_rdata <= dev_reg[reg_addr];
   end

   // reference model
   logic [7:0] ref_mem [int];
   logic [7:0] ref_reg [16];
   int ref_ptr = 0;
   int exp_maddr[$];
   int exp_mdata[$];
   int exp_raddr[$];
   int exp_rdata[$];

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_rd(input int a);
      return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
   endfunction

   // per-clock comparison of the storage strobes against the model
   logic prev_mre = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (exp_maddr.size() == 0) check(0, "R3/R4 unexpected mem write", int'(mem_addr), -1);
            else begin
               check(int'(mem_addr) == exp_maddr[0], "R4 write address", int'(mem_addr), exp_maddr[0]);
               check(int'(mem_wdata) == exp_mdata[0], "R4 write data", int'(mem_wdata), exp_mdata[0]);
               void'(exp_maddr.pop_front());
               void'(exp_mdata.pop_front());
            end
         end
         if (reg_we) begin
            if (exp_raddr.size() == 0) check(0, "R3/R7 unexpected reg write", int'(reg_addr), -1);
            else begin
               check(int'(reg_addr) == exp_raddr[0], "R7 reg index", int'(reg_addr), exp_raddr[0]);
               check(int'(reg_wdata) == exp_rdata[0], "R7 reg data", int'(reg_wdata), exp_rdata[0]);
               void'(exp_raddr.pop_front());
               void'(exp_rdata.pop_front());
            end
         end
         if (mem_re) check(!prev_mre, "R10 read strobe width", 2, 1);
         prev_mre = mem_re;
      end
   end

   task automatic qwait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      m_sda = 1'b1; qwait(Q);
      m_scl = 1'b1; qwait(Q);
      m_sda = 1'b0; qwait(Q);
      m_scl = 1'b0; qwait(Q);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; qwait(Q);
      m_scl = 1'b1; qwait(Q);
      m_sda = 1'b1; qwait(Q);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; qwait(Q);
      m_scl = 1'b1; qwait(2 * Q);
      m_scl = 1'b0; qwait(Q);
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; qwait(Q);
      m_scl = 1'b1; qwait(Q);
      b = sda_line; qwait(Q);
      m_scl = 1'b0; qwait(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      ack = ~a;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic last);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(last);
   endtask

   task automatic mem_wr(input int a, input int n, input logic [7:0] d [4]);
      logic ak;
      int p;
      bus_start;
      send_byte({IDM, DS, a[16], 1'b0}, ak);
      check(ak, "R2 memory slave byte ack", int'(ak), 1);
      send_byte(a[15:8], ak);
      check(ak, "R4 high address ack", int'(ak), 1);
      send_byte(a[7:0], ak);
      check(ak, "R4 low address ack", int'(ak), 1);
      p = a;
      for (int i = 0; i < n; i++) begin
         exp_maddr.push_back(p);
         exp_mdata.push_back(int'(d[i]));
         ref_mem[p] = d[i];
         send_byte(d[i], ak);
         check(ak, "R4 data ack", int'(ak), 1);
         p = (p + 1) & 'h1FFFF;
      end
      bus_stop;
      ref_ptr = p;
   endtask

   task automatic mem_rd(input int a, input int n, input bit set_addr);
      logic ak;
      logic [7:0] v;
      int p;
      if (set_addr) begin
         bus_start;
         send_byte({IDM, DS, a[16], 1'b0}, ak);
         send_byte(a[15:8], ak);
         send_byte(a[7:0], ak);
         p = a;
      end else begin
         p = (a & 'h10000) | (ref_ptr & 'hFFFF);
      end
      bus_start; // R9 repeated START when an address phase preceded
      send_byte({IDM, DS, a[16], 1'b1}, ak);
      check(ak, "R2 read slave byte ack", int'(ak), 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(v, i == n - 1);
         check(v == ref_rd(p), "R6 read data", int'(v), int'(ref_rd(p)));
         p = (p + 1) & 'h1FFFF;
      end
      qwait(3);
      check(sda_oe == 1'b0, "R8 SDA released after master NACK", int'(sda_oe), 0);
      bus_stop;
      ref_ptr = p;
   endtask

   initial begin
      logic ak;
      logic [7:0] v;
      for (int i = 0; i < 16; i++) begin
         dev_reg[i] = 8'h00;
         ref_reg[i] = 8'h00;
      end
      mem_rdata = 8'h00;
      reg_rdata = 8'h00;
      qwait(5);
      check(sda_oe == 1'b0, "R1 sda_oe at reset", int'(sda_oe), 0);
      check({mem_we, mem_re, reg_we, reg_re} == 4'b0, "R1 strobes at reset",
            int'({mem_we, mem_re, reg_we, reg_re}), 0);
      rst_n = 1'b1;
      qwait(5);
      check(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);

      // R4 burst with bit 16 set, R6 readback, R8 current-address continuation
      mem_wr('h11234, 4, '{8'hC1, 8'hC2, 8'hC3, 8'hC4});
      mem_rd('h11234, 3, 1'b1);
      mem_rd('h10000, 1, 1'b0);

      // R5 wrap across the top of memory
      mem_wr('h1FFFF, 2, '{8'h5A, 8'hA5, 8'h00, 8'h00});
      mem_rd('h1FFFF, 2, 1'b1);

      // R3 wrong device-select: NACK and no effect
      bus_start;
      send_byte({IDM, ~DS, 1'b0, 1'b0}, ak);
      check(!ak, "R3 foreign device-select NACK", int'(ak), 0);
      send_byte(8'h00, ak);
      check(!ak, "R3 ignored byte NACK", int'(ak), 0);
      send_byte(8'h00, ak);
      send_byte(8'h77, ak);
      check(!ak, "R3 ignored data NACK", int'(ak), 0);
      bus_stop;
      mem_rd('h00000, 1, 1'b1);

      // R2/R3 unknown identity
      bus_start;
      send_byte({4'b0101, DS, 1'b0, 1'b0}, ak);
      check(!ak, "R2 unknown identity NACK", int'(ak), 0);
      bus_stop;

      // R7 control identity, bit 1 set as don't-care, index wrap 14->15->0
      bus_start;
      send_byte({IDC, DS, 1'b1, 1'b0}, ak);
      check(ak, "R7 control slave ack", int'(ak), 1);
      send_byte(8'h0E, ak);
      check(ak, "R7 index ack", int'(ak), 1);
      for (int i = 0; i < 3; i++) begin
         exp_raddr.push_back((14 + i) % 16);
         exp_rdata.push_back('h11 * (i + 1));
         ref_reg[(14 + i) % 16] = 8'(8'h11 * (i + 1));
         send_byte(8'(8'h11 * (i + 1)), ak);
         check(ak, "R7 reg data ack", int'(ak), 1);
      end
      bus_stop;
      bus_start;
      send_byte({IDC, DS, 1'b0, 1'b0}, ak);
      send_byte(8'h0E, ak);
      bus_start;
      send_byte({IDC, DS, 1'b0, 1'b1}, ak);
      check(ak, "R7 control read ack", int'(ak), 1);
      for (int i = 0; i < 3; i++) begin
         recv_byte(v, i == 2);
         check(v == ref_reg[(14 + i) % 16], "R7 reg readback", int'(v),
               int'(ref_reg[(14 + i) % 16]));
      end
      bus_stop;

      // R9 START in the middle of a byte aborts it
      bus_start;
      send_byte({IDM, DS, 1'b0, 1'b0}, ak);
      put_bit(1'b1);
      put_bit(1'b0);
      put_bit(1'b1);
      mem_wr('h00010, 1, '{8'h66, 8'h00, 8'h00, 8'h00});
      mem_rd('h00010, 1, 1'b1);

      qwait(20);
      check(exp_maddr.size() == 0, "R4 all expected writes seen", exp_maddr.size(), 0);
      check(exp_raddr.size() == 0, "R7 all expected reg writes seen", exp_raddr.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule